// File: doc/BRIEF.md
# Input Level Detector Integrator

This block measures how strong the incoming signed sample stream is, so that an external loop can steer the analog IF gain ahead of the converter. Every enabled input sample is folded to its magnitude. A programmed threshold is subtracted from that magnitude, and the signed difference is summed over a programmed number of enabled samples. The finished sum is therefore the total input error against the threshold. With a threshold of zero, the sum divided by the sample count is the mean input magnitude.

The host writes one configuration word and then pulses a start strobe. The start strobe copies the configuration into working registers and begins an interval. In single mode the detector measures one interval and then stops. In continuous mode it begins the next interval on the very next enabled sample. Each finished sum lands in a result register and raises a done flag, which stays up until the host acknowledges the read.

The control is a two-state machine:
- `LD_IDLE` moves to `LD_RUN` on a start strobe (transition *arm*).
- `LD_RUN` stays in `LD_RUN` on a start strobe (transition *restart*), or when an interval ends in continuous mode (transition *wrap*).
- `LD_RUN` returns to `LD_IDLE` when an interval ends in single mode (transition *finish*).

Top module: `lvl_detect`

## Requirements
- R1: After reset, `busy` is 0, `res_done` is 0 and `res_sum` is 0.
- R2: The configuration word has three fields:
  - the threshold (unsigned) in bits SMP_W-1:0;
  - the interval field in the next CNT_W bits;
  - the mode bit in the top bit, where 1 selects continuous mode and 0 selects single mode.

  A write with `cfg_we` high is stored on that clock edge. The stored value takes effect at the next start strobe.
- R3: Each counted sample adds |x| − threshold to the sum, where x is the two's-complement sample and the most negative code has magnitude 2^(SMP_W-1). With threshold 0 the result is the sum of magnitudes.
- R4: Only cycles with `smp_valid` high are counted. An interval holds exactly interval-field + 1 valid samples, whatever idle cycles lie between them.
- R5: A start strobe begins a new interval from any state. The sample present in the strobe cycle is not counted. Any partial sum is discarded, and no result is produced in that cycle.
- R6: In single mode, `busy` falls after the last sample of the interval. Later samples change neither the result nor the done flag.
- R7: In continuous mode, `busy` stays high. The valid sample right after an interval's last sample is the first sample of the next interval, using the same configuration.
- R8: On the clock edge that takes an interval's last sample, `res_sum` is loaded with the interval sum and `res_done` is set. `res_sum` holds at all other times.
- R9: `rd_ack` clears `res_done`. If `rd_ack` arrives in the same cycle as an interval ending, the flag is set.
- R10: The sum is CNT_W+SMP_W+1 bits wide. The sum is exact, with no overflow, for any interval length, threshold and sample values.
- R11: A configuration write while an interval is running does not change that interval's threshold, length or mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_word | input | SMP_W+CNT_W+1 | Configuration word: threshold, interval field, mode |
| start | input | 1 | Start strobe; begins or restarts an interval |
| smp_valid | input | 1 | Sample enable |
| smp_data | input | SMP_W | Two's-complement input sample |
| rd_ack | input | 1 | Host read acknowledge; clears the done flag |
| busy | output | 1 | High while in `LD_RUN` |
| res_done | output | 1 | A new result is waiting |
| res_sum | output | CNT_W+SMP_W+1 | Signed sum of the last finished interval |

## Verification
The bench builds the detector with 4-bit samples and a 3-bit interval field, which gives an 8-bit configuration word and an 8-bit sum. At this size every sample code can be paired with every threshold code as a one-sample interval. Every interval length from one to eight samples can also be run, with idle gaps between the samples. The narrow sum lets the extreme cases be reached directly: the largest negative total (−120) and the largest positive total (+64) test whether the sum is wide enough with no margin to spare.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    // Control states of the level detector
    typedef enum logic {
        LD_IDLE = 1'b0,
        LD_RUN  = 1'b1
    } ld_state_e;

endpackage

// File: rtl/lvl_err.sv
// Folds a signed sample to its magnitude and subtracts the threshold.
module lvl_err #(
    parameter int SMP_W = 14
) (
    input  logic signed [SMP_W-1:0] smp,
    input  logic        [SMP_W-1:0] thr,
    output logic signed [SMP_W:0]   err
);

    logic [SMP_W-1:0] mag;

    always_comb begin
        if (smp[SMP_W-1]) begin
            mag = $unsigned(-smp);
        end else begin
            mag = $unsigned(smp);
        end
        err = $signed({1'b0, mag}) - $signed({1'b0, thr});
    end

endmodule

// File: rtl/lvl_ctrl.sv
// State machine, interval counter and working copy of the configuration.
module lvl_ctrl
    import lvl_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] cfg_thr,
    input  logic [CNT_W-1:0] cfg_len,
    input  logic             cfg_mode,
    output logic [SMP_W-1:0] thr_q,
    output logic             acc_clr,
    output logic             acc_en,
    output logic             fin,
    output logic             busy
);

    ld_state_e        state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len_q;
    logic             mode_q;
    logic             at_last;

    assign at_last = (cnt == len_q);

    always_comb begin
        state_nx = state;
        unique case (state)
            LD_IDLE: begin
                if (start) state_nx = LD_RUN;
            end
            LD_RUN: begin
                if (!start && smp_valid && at_last && !mode_q) state_nx = LD_IDLE;
            end
            default: state_nx = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LD_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q  <= '0;
            len_q  <= '0;
            mode_q <= 1'b0;
            cnt    <= '0;
        end else if (start) begin
            thr_q  <= cfg_thr;
            len_q  <= cfg_len;
            mode_q <= cfg_mode;
            cnt    <= '0;
        end else if (acc_en) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        busy    = (state == LD_RUN);
        acc_clr = start;
        acc_en  = busy && smp_valid && !start;
        fin     = acc_en && at_last;
    end

    // R4: the counter never passes the programmed last position
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt <= len_q));

    // R5: a strobe always leaves the block running from count zero
    p_start_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && cnt == '0));

    // R6: single mode stops after its interval
    p_single_stops_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !mode_q) |=> !busy);

    // R7: continuous mode keeps running across the boundary
    p_cont_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && mode_q) |=> (busy && cnt == '0));

endmodule

// File: rtl/lvl_acc.sv
// Error accumulator, result register and done flag.
module lvl_acc #(
    parameter int ERR_W = 15,
    parameter int ACC_W = 31
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    en,
    input  logic                    fin,
    input  logic signed [ERR_W-1:0] err,
    input  logic                    rd_ack,
    output logic        [ACC_W-1:0] res,
    output logic                    done
);

    localparam int EXT_W = ACC_W - ERR_W;

    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] err_x;
    logic signed [ACC_W-1:0] sum_nx;

    always_comb begin
        err_x  = {{EXT_W{err[ERR_W-1]}}, err};
        sum_nx = sum + err_x;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
            res <= '0;
        end else if (clr) begin
            sum <= '0;
        end else if (fin) begin
            res <= sum_nx;
            sum <= '0;
        end else if (en) begin
            sum <= sum_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      done <= 1'b0;
        else if (fin)    done <= 1'b1;
        else if (rd_ack) done <= 1'b0;
    end

    // R5: strobe discards the partial sum
    p_clr_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sum == '0));

    // R8: an interval end raises the flag
    p_done_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> done);

    // R8: result holds between interval ends
    p_res_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fin |=> $stable(res));

    // R9: acknowledge clears the flag when no interval ends
    p_done_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !fin) |=> !done);

    // R10: adding two same-sign values never flips the sign of the sum
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && sum[ACC_W-1] == err_x[ACC_W-1]) |-> (sum_nx[ACC_W-1] == sum[ACC_W-1]));

endmodule

// File: rtl/lvl_detect.sv
// Top: configuration register, error path, control and accumulator.
module lvl_detect
    import lvl_pkg::*;
#(
    parameter int SMP_W = 14,
    parameter int CNT_W = 16,
    localparam int CFG_W = SMP_W + CNT_W + 1,
    localparam int ERR_W = SMP_W + 1,
    localparam int ACC_W = CNT_W + ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             start,
    input  logic             smp_valid,
    input  logic [SMP_W-1:0] smp_data,
    input  logic             rd_ack,
    output logic             busy,
    output logic             res_done,
    output logic [ACC_W-1:0] res_sum
);

    localparam int MODE_BIT = CFG_W - 1;

    logic [CFG_W-1:0]        cfg_q;
    logic [SMP_W-1:0]        thr_q;
    logic signed [ERR_W-1:0] err;
    logic                    acc_clr;
    logic                    acc_en;
    logic                    fin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_word;
    end

    lvl_ctrl #(
        .SMP_W (SMP_W),
        .CNT_W (CNT_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .smp_valid (smp_valid),
        .cfg_thr   (cfg_q[SMP_W-1:0]),
        .cfg_len   (cfg_q[SMP_W+CNT_W-1:SMP_W]),
        .cfg_mode  (cfg_q[MODE_BIT]),
        .thr_q     (thr_q),
        .acc_clr   (acc_clr),
        .acc_en    (acc_en),
        .fin       (fin),
        .busy      (busy)
    );

    lvl_err #(
        .SMP_W (SMP_W)
    ) u_err (
        .smp (smp_data),
        .thr (thr_q),
        .err (err)
    );

    lvl_acc #(
        .ERR_W (ERR_W),
        .ACC_W (ACC_W)
    ) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (acc_clr),
        .en     (acc_en),
        .fin    (fin),
        .err    (err),
        .rd_ack (rd_ack),
        .res    (res_sum),
        .done   (res_done)
    );

    // R1: nothing is pending right after reset is released
    p_reset_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !res_done && res_sum == '0));

endmodule

// File: tb/lvl_detect_bench.sv
module lvl_detect_bench;

    localparam int SW = 4;
    localparam int CW = 3;
    localparam int AW = CW + SW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [SW+CW:0] cfg_word = '0;
    logic          start = 1'b0;
    logic          smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic          rd_ack = 1'b0;
    logic          busy;
    logic          res_done;
    logic [AW-1:0] res_sum;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    lvl_detect #(.SMP_W(SW), .CNT_W(CW)) u_lvl_detect (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
        .start(start), .smp_valid(smp_valid), .smp_data(smp_data),
        .rd_ack(rd_ack), .busy(busy), .res_done(res_done), .res_sum(res_sum)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int sval(input int raw);
        return ((raw & 15) >= 8) ? (raw & 15) - 16 : (raw & 15);
    endfunction

    function automatic int magv(input int raw);
        int s;
        s = sval(raw);
        return (s < 0) ? -s : s;
    endfunction

    function automatic int res();
        return int'($signed(res_sum));
    endfunction

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic cfg(input int thr, input int len, input int mode);
        cfg_word = 8'(mode * 128 + len * 16 + thr);
        cfg_we = 1'b1;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic go();
        start = 1'b1;
        cyc();
        start = 1'b0;
    endtask

    task automatic feed(input int raw);
        smp_valid = 1'b1;
        smp_data = 4'(raw);
        cyc();
        smp_valid = 1'b0;
    endtask

    task automatic ack();
        rd_ack = 1'b1;
        cyc();
        rd_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int exp;
        int prev;
        repeat (3) cyc();
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(res_done), 0);
        check("R1 sum", res(), 0);
        rst_n = 1'b1;
        cyc();

        // R3: every sample code against every threshold, one-sample intervals
        for (int thr = 0; thr < 16; thr++) begin
            for (int raw = 0; raw < 16; raw++) begin
                cfg(thr, 0, 0);
                go();
                feed(raw);
                check("R3 sum", res(), magv(raw) - thr);
                check("R8 done set", int'(res_done), 1);
                check("R6 stopped", int'(busy), 0);
                ack();
                check("R9 done clear", int'(res_done), 0);
            end
        end

        // R4: every interval length with idle gaps between samples
        exp = 0;
        for (int len = 0; len < 8; len++) begin
            cfg(3, len, 0);
            go();
            exp = 0;
            for (int k = 0; k <= len; k++) begin
                int raw;
                raw = (k * 5 + len * 3 + 1) % 16;
                exp += magv(raw) - 3;
                feed(raw);
                if (k < len) begin
                    check("R4 not yet done", int'(res_done), 0);
                    check("R4 still busy", int'(busy), 1);
                    cyc();
                end
            end
            check("R4 sum", res(), exp);
            check("R4 done", int'(res_done), 1);
            ack();
        end

        // R6: samples after a single interval are ignored
        prev = exp;
        feed(7); feed(9); feed(2);
        check("R6 busy", int'(busy), 0);
        check("R6 done", int'(res_done), 0);
        check("R6 sum", res(), prev);

        // R8: result holds until the next interval ends; zero threshold
        cfg(0, 3, 0);
        go();
        feed(1); feed(2); feed(3);
        check("R8 hold", res(), prev);
        feed(4);
        check("R3 zero threshold", res(), 10);
        ack();

        // R7: continuous mode, three back-to-back intervals
        cfg(2, 2, 1);
        go();
        for (int g = 0; g < 3; g++) begin
            int e;
            e = 0;
            for (int k = 0; k < 3; k++) begin
                int raw;
                raw = (g * 7 + k * 3 + 9) % 16;
                e += magv(raw) - 2;
                if (g == 2 && k == 2) rd_ack = 1'b1;
                feed(raw);
                rd_ack = 1'b0;
            end
            check("R7 sum", res(), e);
            check("R7 busy", int'(busy), 1);
            check("R9 done", int'(res_done), 1);
        end
        ack();
        check("R9 cleared", int'(res_done), 0);

        // R5: restart mid-interval with a sample in the strobe cycle
        cfg(1, 4, 0);
        go();
        feed(5); feed(6);
        start = 1'b1; smp_valid = 1'b1; smp_data = 4'd7;
        cyc();
        start = 1'b0; smp_valid = 1'b0;
        check("R5 no result", int'(res_done), 0);
        exp = 0;
        for (int r = 8; r <= 12; r++) begin
            exp += magv(r) - 1;
            feed(r);
        end
        check("R5 sum", res(), exp);
        ack();

        // R11 / R2: configuration write during an interval
        cfg(0, 1, 0);
        go();
        feed(3);
        cfg(15, 1, 0);
        feed(4);
        check("R11 old threshold", res(), 7);
        ack();
        go();
        feed(3); feed(4);
        check("R2 new threshold", res(), -23);
        ack();

        // R10: extremes of the sum
        cfg(15, 7, 0);
        go();
        for (int k = 0; k < 8; k++) feed(0);
        check("R10 most negative", res(), -120);
        ack();
        cfg(0, 7, 0);
        go();
        for (int k = 0; k < 8; k++) feed(8);
        check("R10 most positive", res(), 64);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule